// File: doc/BRIEF.md
# Three-Wire Serial Configuration Master

This block lets on-chip control logic program one external device over a three-wire serial link: a serial clock, an active-low chip select and a single data line that both sides share. A caller presents one request at a time: a read flag, a 13-bit register address and a data byte. The block runs one fixed 24-bit frame for that request. For a readback it stops driving the shared line partway through the frame and collects the byte that the device returns. The data line is split into an output, an output enable and an input, so the pad ring can build the bidirectional pin.

Writes run the serial clock fast and readbacks run it slowly. The two half-periods, counted in system clock cycles, are set by parameters. Between frames, chip select stays high for one full serial clock period before the block reports completion. This guarantees a release between back-to-back accesses.

The controller is a five-state machine:
- **IDLE**: ready is high. An accepted request (`req_valid` while in IDLE) moves it to **CLK_LO**.
- **CLK_LO**: chip select is low and the serial clock is low. When the half-period expires it moves to **CLK_HI**; this is the rising edge, where read bits are captured.
- **CLK_HI**: the serial clock is high. When the half-period expires it returns to **CLK_LO** with the next bit (the falling edge). After the 24th bit it moves to **GAP** instead.
- **GAP**: chip select is high for two half-periods, then the machine moves to **DONE**.
- **DONE**: a one-cycle completion pulse, then back to **IDLE**.

Top module: `cfg_spi3_master`

## Requirements
- R1: A frame carries, MSB first, the read flag in bit 23 (1 = readback, 0 = write), zeros in bits 22:21, the address in bits 20:8 and the data byte in bits 7:0. A bit is driven on `sdio_out` whenever the master owns the line and chip select is low.
- R2: Each accepted request produces exactly one chip-select-low window containing exactly 24 rising edges of the serial clock.
- R3: `sclk` is low whenever `cs_n` is high. The serial clock toggles only inside a frame.
- R4: Each serial clock phase, high or low, lasts `WR_HALF` system cycles for a write (default 4, a 40 ns period at 200 MHz) and `RD_HALF` cycles for a readback (default 25, a 250 ns period).
- R5: The first bit is presented when `cs_n` falls. `sdio_out` changes only on a falling serial clock transition and stays stable while `sclk` is high.
- R6: During a readback, `sdio_oe` drops at the falling edge that ends bit 16 and stays low until `cs_n` rises. `sdio_in` is sampled at each of the last 8 rising edges, MSB first.
- R7: After the 24th bit, `cs_n` stays high (and `busy` stays high) for two half-periods before completion is reported.
- R8: `done` is a one-cycle pulse that follows the gap. `ready` is high only in IDLE, and never between acceptance and the `done` pulse. A request presented while `ready` is low is ignored.
- R9: `rd_data` holds the byte from the most recent readback, updated by the time `done` pulses. A write leaves it unchanged.
- R10: After reset: `cs_n`=1, `sclk`=0, `sdio_oe`=1, `busy`=0, `done`=0, `ready`=1, `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when ready is high |
| req_read | input | 1 | 1 = readback, 0 = write |
| req_addr | input | 13 | Register address |
| req_data | input | 8 | Write data (sent as zero bits of no meaning on readback frames if the caller wishes) |
| ready | output | 1 | Block is idle and can accept a request |
| busy | output | 1 | A frame or its trailing gap is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last readback byte |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| sdio_out | output | 1 | Serial data out |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| sdio_in | input | 1 | Serial data in from the shared pin |

## Verification
The assertions assume that the caller holds `req_read`, `req_addr` and `req_data` steady in the cycle a request is accepted. They also assume that `sdio_in` settles before the rising serial clock edge at which it is captured. The bench's device model drives `sdio_in` from a count of serial clock rises, so each returned bit is stable for the whole half-period before it is sampled. Requests are driven only on falling system clock edges. One request is held high across a whole busy frame, which checks that it is taken only once IDLE returns.

// File: rtl/cfg_spi3_pkg.sv
package cfg_spi3_pkg;

    localparam int FRAME_W  = 24;
    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 8;
    localparam int RSVD_W   = FRAME_W - 1 - ADDR_W - DATA_W;
    localparam int BIT_W    = $clog2(FRAME_W);
    localparam int RX_START = FRAME_W - DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_GAP,
        ST_DONE
    } spi3_state_e;

    function automatic logic [FRAME_W-1:0] pack_frame(
        input logic              rd,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] data
    );
        return {rd, {RSVD_W{1'b0}}, addr, data};
    endfunction

endpackage

// File: rtl/spi3_half_timer.sv
module spi3_half_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi3_shift_path.sv
module spi3_shift_path #(
    parameter int TX_W = 24,
    parameter int RX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            shift,
    input  logic            capture,
    input  logic            sdin,
    output logic            sdout,
    output logic [RX_W-1:0] rx_byte
);
    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    assign sdout   = tx_q[TX_W-1];
    assign rx_byte = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (shift) begin
            tx_q <= {tx_q[TX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[RX_W-2:0], sdin};
        end
    end
endmodule

// File: rtl/cfg_spi3_master.sv
module cfg_spi3_master
    import cfg_spi3_pkg::*;
#(
    parameter int WR_HALF = 4,
    parameter int RD_HALF = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic              sdio_in
);
    localparam int MAX_HALF = (RD_HALF > WR_HALF) ? RD_HALF : WR_HALF;
    localparam int CNT_W    = $clog2(2 * MAX_HALF + 1);

    spi3_state_e        state_q, state_d;
    logic [CNT_W-1:0]   half_q;
    logic [CNT_W-1:0]   tim_lim;
    logic               rd_q;
    logic [BIT_W-1:0]   bit_q;
    logic [DATA_W-1:0]  rd_data_q;
    logic [DATA_W-1:0]  rx_byte;
    logic               accept, tick, last_bit, in_frame;
    logic               do_shift, do_capture;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign last_bit = (bit_q == BIT_W'(FRAME_W - 1));
    assign in_frame = (state_q == ST_CLK_LO) || (state_q == ST_CLK_HI);
    assign tim_lim  = (state_q == ST_GAP) ? (half_q << 1) : half_q;

    assign do_shift   = (state_q == ST_CLK_HI) && tick && !last_bit;
    assign do_capture = (state_q == ST_CLK_LO) && tick && rd_q
                        && (bit_q >= BIT_W'(RX_START));

    spi3_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .lim   (tim_lim),
        .tick  (tick)
    );

    spi3_shift_path #(.TX_W(FRAME_W), .RX_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (pack_frame(req_read, req_addr, req_data)),
        .shift    (do_shift),
        .capture  (do_capture),
        .sdin     (sdio_in),
        .sdout    (sdio_out),
        .rx_byte  (rx_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_CLK_LO;
            ST_CLK_LO: if (tick)   state_d = ST_CLK_HI;
            ST_CLK_HI: if (tick)   state_d = last_bit ? ST_GAP : ST_CLK_LO;
            ST_GAP:    if (tick)   state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        cs_n  = 1'b1;
        sclk  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ready = 1'b1;
            ST_CLK_LO: begin busy = 1'b1; cs_n = 1'b0; end
            ST_CLK_HI: begin busy = 1'b1; cs_n = 1'b0; sclk = 1'b1; end
            ST_GAP:    busy = 1'b1;
            ST_DONE:   done = 1'b1;
            default:   ready = 1'b0;
        endcase
    end

    assign sdio_oe = !(rd_q && in_frame && (bit_q >= BIT_W'(RX_START)));
    assign rd_data = rd_data_q;

    // frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q    <= CNT_W'(WR_HALF);
            rd_q      <= 1'b0;
            bit_q     <= '0;
            rd_data_q <= '0;
        end else if (accept) begin
            half_q <= req_read ? CNT_W'(RD_HALF) : CNT_W'(WR_HALF);
            rd_q   <= req_read;
            bit_q  <= '0;
        end else if ((state_q == ST_CLK_HI) && tick) begin
            if (!last_bit) begin
                bit_q <= bit_q + 1'b1;
            end else if (rd_q) begin
                rd_data_q <= rx_byte;
            end
        end
    end
endmodule

// File: rtl/spi3_master_chk.sv
module spi3_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdio_out,
    input logic sdio_oe,
    input logic busy,
    input logic done,
    input logic ready
);
    logic       sclk_prev, cs_prev;
    logic [5:0] rises;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
            rises     <= '0;
        end else begin
            sclk_prev <= sclk;
            cs_prev   <= cs_n;
            if (cs_n) begin
                rises <= '0;
            end else if (sclk && !sclk_prev) begin
                rises <= rises + 1'b1;
            end
        end
    end

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && sclk_prev) |-> $stable(sdio_out));

    // R6
    release_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdio_oe |-> !cs_n);

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_prev) |-> (rises == 6'd24));

    // R7
    gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_prev) |-> busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!busy && !done && cs_n));
endmodule

bind cfg_spi3_master spi3_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe),
    .busy     (busy),
    .done     (done),
    .ready    (ready)
);

// File: tb/tb_cfg_spi3_master.sv
module tb_cfg_spi3_master;
    localparam int WRH = 4;
    localparam int RDH = 25;

    typedef struct packed {
        logic cs, sc, sd, oe, bz, dn, rdy;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_read = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       ready, busy, done, sclk, cs_n, sdio_out, sdio_oe, sdio_in;
    logic [7:0] rd_data;
    logic [7:0] dev_byte = 8'h00;
    logic [4:0] dcnt = '0;

    int   tests = 0, fails = 0, cycles = 0;
    exp_t q[$];
    logic last_ready = 1'b1;
    logic last_done  = 1'b0;
    logic accepted;
    logic [7:0] last_rd = 8'h00;

    always #2.5 clk = ~clk;

    cfg_spi3_master #(.WR_HALF(WRH), .RD_HALF(RDH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_data(req_data), .ready(ready), .busy(busy),
        .done(done), .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdio_in(sdio_in)
    );

    // device model: counts serial clock rises inside a frame
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) dcnt <= '0;
        else      dcnt <= dcnt + 1'b1;
    end
    assign sdio_in = (dcnt >= 5'd16 && dcnt <= 5'd23) ? dev_byte[3'(5'd23 - dcnt)] : 1'b0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic exp_t idle_e();
        exp_t e;
        e = '{cs:1'b1, sc:1'b0, sd:1'b0, oe:1'b1, bz:1'b0, dn:1'b0, rdy:1'b1};
        return e;
    endfunction

    task automatic push_frame(input logic rd, input logic [12:0] a, input logic [7:0] d);
        logic [23:0] fr;
        int h;
        exp_t e;
        fr = {rd, 2'b00, a, d};            // R1 layout
        h  = rd ? RDH : WRH;               // R4
        for (int b = 0; b < 24; b++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int k = 0; k < h; k++) begin
                    e.cs = 1'b0; e.sc = ph[0]; e.sd = fr[23-b];
                    e.oe = !(rd && b >= 16);   // R6
                    e.bz = 1'b1; e.dn = 1'b0; e.rdy = 1'b0;
                    q.push_back(e);
                end
            end
        end
        for (int k = 0; k < 2*h; k++) begin  // R7
            e = '{cs:1'b1, sc:1'b0, sd:1'b0, oe:1'b1, bz:1'b1, dn:1'b0, rdy:1'b0};
            q.push_back(e);
        end
        e = '{cs:1'b1, sc:1'b0, sd:1'b0, oe:1'b1, bz:1'b0, dn:1'b1, rdy:1'b0};
        q.push_back(e);                      // R8
    endtask

    task automatic cmp(input string req, input string nm, input logic act, input logic ex);
        tests++;
        if (act !== ex) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", req, nm, act, ex, cycles);
        end
    endtask

    task automatic step();
        exp_t e;
        accepted = 1'b0;
        if (req_valid && last_ready) begin
            push_frame(req_read, req_addr, req_data);
            accepted = 1'b1;
        end
        @(negedge clk);
        e = (q.size() > 0) ? q.pop_front() : idle_e();
        cmp("R2", "cs_n", cs_n, e.cs);
        cmp("R4", "sclk", sclk, e.sc);
        cmp("R6", "sdio_oe", sdio_oe, e.oe);
        if (!e.cs && e.oe) cmp("R1", "sdio_out", sdio_out, e.sd);
        cmp("R7", "busy", busy, e.bz);
        cmp("R8", "done", done, e.dn);
        cmp("R8", "ready", ready, e.rdy);
        last_ready = e.rdy;
        last_done  = e.dn;
    endtask

    task automatic check_byte(input string req, input logic [7:0] act, input logic [7:0] ex);
        tests++;
        if (act !== ex) begin
            fails++;
            $display("FAIL %s rd_data: actual=%h expected=%h", req, act, ex);
        end
    endtask

    task automatic run_req(input logic rd, input logic [12:0] a, input logic [7:0] d,
                           input logic [7:0] dev);
        dev_byte  = dev;
        req_read  = rd; req_addr = a; req_data = d; req_valid = 1'b1;
        do step(); while (!accepted);
        req_valid = 1'b0;
        do step(); while (!last_done);
        if (rd) last_rd = dev;
        check_byte(rd ? "R6" : "R9", rd_data, last_rd);   // R9 readback holding
    endtask

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        cmp("R10", "cs_n", cs_n, 1'b1);
        cmp("R10", "sclk", sclk, 1'b0);
        cmp("R10", "sdio_oe", sdio_oe, 1'b1);
        cmp("R10", "busy", busy, 1'b0);
        cmp("R10", "done", done, 1'b0);
        cmp("R10", "ready", ready, 1'b1);
        check_byte("R10", rd_data, 8'h00);
        rst_n = 1'b1;
        repeat (2) step();

        // R1 R4 R5 write frames with different patterns
        run_req(1'b0, 13'h0A5, 8'h3C, 8'h00);
        run_req(1'b0, 13'h1FFF, 8'hFF, 8'h00);
        run_req(1'b0, 13'h0000, 8'h00, 8'h00);
        // R6 readback
        run_req(1'b1, 13'h0F0, 8'h00, 8'hA7);
        // R9 write leaves rd_data alone
        run_req(1'b0, 13'h123, 8'h81, 8'h00);
        run_req(1'b1, 13'h1555, 8'hFF, 8'h5A);

        // R8 R7 request held while busy: taken only after done, once
        dev_byte = 8'hC3;
        req_read = 1'b0; req_addr = 13'h010; req_data = 8'h96; req_valid = 1'b1;
        do step(); while (!accepted);
        req_read = 1'b1; req_addr = 13'h0777; req_data = 8'h00;
        do step(); while (!accepted);
        req_valid = 1'b0;
        do step(); while (!last_done);
        last_rd = 8'hC3;
        check_byte("R6", rd_data, last_rd);
        repeat (5) step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule